// File: doc/BRIEF.md
# Master Interrupt Mask and Routing Registers

This block is the system-level register set of an interrupt controller. It samples 32 level-sensitive device interrupt lines into a master pending register every clock. It keeps a disabled mask in which a set bit blocks the matching source, and bit 31 of that mask turns off every hard interrupt at once. It also holds the index of the processor that is to receive hard interrupts. Later stages turn the sources into priority levels and drive each processor's outputs. Those stages read this block's state through dedicated output ports.

Software reaches the block through a word-addressed 32-bit port with five live word slots. One slot reads pending. One reads the mask. One clears mask bits, which enables sources. One sets mask bits, which disables sources. One selects the target processor. A fixed group of mask bits has no source behind it. Those bits are held set in hardware, can never be changed by a write, and always read back as zero.

Top module: `irq_master_regs`

## Requirements
- R1: After reset, the pending register is zero, the target index is zero, and the disabled mask equals 0x0FA2007F. A read of word 1 then returns 0.
- R2: The pending register captures `devIrq` on every rising clock edge. Bit n is set while line n is high and clear while it is low.
- R3: A read of word 0 returns the pending register with bit 31 forced to 0.
- R4: A read of word 1 returns the disabled mask ANDed with the implemented-bit set 0xF05DFF80.
- R5: A write to word 2 clears every disabled-mask bit that is set in both the write data and 0xF05DFF80. The reserved bits 0x0FA2007F stay set.
- R6: A write to word 3 sets every disabled-mask bit that is set in both the write data and 0xF05DFF80. Bit 31 is the global disable.
- R7: Writes to the mask, to either word 2 or word 3, never change the pending register.
- R8: A write to word 4 loads the target index with the write data ANDed with (NUM_CPU-1). With the default of 4 processors, this is the low 2 bits.
- R9: Writes to words 0, 1 and 5 to 7 change no state. Reads of words 2 to 7 return 0.
- R10: `hardPending` equals pending AND NOT disabled mask. It is all zero whenever mask bit 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devIrq | input | 32 | Level device interrupt lines |
| busAddr | input | 3 | Word index of the access |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| pendingOut | output | 32 | Raw master pending register |
| disabledOut | output | 32 | Raw disabled mask, reserved bits included |
| targetCpu | output | 2 | Processor that receives hard interrupts |
| hardPending | output | 32 | Sources that are pending and enabled |

## Verification
Assertions check the following on every cycle:
- Pending is a one-cycle image of the device lines.
- The reserved mask bits never clear.
- Each clear, set or target write has exactly its masked effect on the next cycle.
- Word 0 never shows bit 31, and a mask write leaves pending unchanged.

Only the bench's scenarios can show the full set of readback values, the absorbed writes to read-only and unused slots, the global kill through `hardPending`, and reset in the middle of a run.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam logic [DATA_W-1:0] RSVD_BITS = 32'h0FA2007F;
  localparam logic [DATA_W-1:0] IMPL_BITS = ~RSVD_BITS;
  localparam int KILL_BIT = 31;

  typedef enum logic [2:0] {
    SEL_PEND = 3'd0,
    SEL_MASK = 3'd1,
    SEL_NONE = 3'd2
  } rdSel_e;

  typedef struct packed {
    logic clrMask;
    logic setMask;
    logic setTarget;
  } strobes_t;
endpackage

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
  import irqm_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output strobes_t          stb,
  output rdSel_e            rdSel
);
  always_comb begin
    stb = '0;
    if (busWr) begin
      case (busAddr)
        3'd2:    stb.clrMask   = 1'b1;
        3'd3:    stb.setMask   = 1'b1;
        3'd4:    stb.setTarget = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (busAddr)
      3'd0:    rdSel = SEL_PEND;
      3'd1:    rdSel = SEL_MASK;
      default: rdSel = SEL_NONE;
    endcase
  end

  // R7, R9: a set or clear strobe never fires together with a target strobe
  always_comb begin
    if ($countones(stb) > 1) begin
      $error("p_one_strobe_r9: more than one strobe active");
    end
  end
endmodule

// File: rtl/irqm_datapath.sv
module irqm_datapath
  import irqm_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] devIrq,
  input  logic [DATA_W-1:0] busWdata,
  input  strobes_t          stb,
  input  rdSel_e            rdSel,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] pendingQ,
  output logic [DATA_W-1:0] disabledQ,
  output logic [TGT_W-1:0]  targetQ,
  output logic [DATA_W-1:0] hardPending
);
  logic [DATA_W-1:0] wrBits;
  logic [TGT_W-1:0]  tgtMask;
  logic              seenClk;

  assign wrBits  = busWdata & IMPL_BITS;
  assign tgtMask = TGT_W'(NUM_CPU - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ  <= '0;
      disabledQ <= RSVD_BITS;
      targetQ   <= '0;
      seenClk   <= 1'b0;
    end else begin
      seenClk  <= 1'b1;
      pendingQ <= devIrq;
      if (stb.clrMask) disabledQ <= disabledQ & ~wrBits;
      else if (stb.setMask) disabledQ <= disabledQ | wrBits;
      if (stb.setTarget) targetQ <= busWdata[TGT_W-1:0] & tgtMask;
    end
  end

  always_comb begin
    case (rdSel)
      SEL_PEND: busRdata = pendingQ & ~(DATA_W'(1) << KILL_BIT);
      SEL_MASK: busRdata = disabledQ & IMPL_BITS;
      default:  busRdata = '0;
    endcase
  end

  assign hardPending = disabledQ[KILL_BIT] ? '0 : (pendingQ & ~disabledQ);

  p_pend_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    seenClk |-> pendingQ == $past(devIrq));
  p_rsvd_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    seenClk |-> (disabledQ & RSVD_BITS) == RSVD_BITS);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrMask |=> (disabledQ & $past(wrBits)) == '0);
  p_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.setMask |=> (disabledQ & $past(wrBits)) == $past(wrBits));
  p_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.setTarget |=> targetQ == ($past(busWdata[TGT_W-1:0]) & tgtMask));
  p_target_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seenClk && !stb.setTarget) |=> $stable(targetQ));
  p_word0_top_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdSel == SEL_PEND |-> busRdata[KILL_BIT] == 1'b0);
  p_kill_r10: assert property (@(posedge clk) disable iff (!rstN)
    disabledQ[KILL_BIT] |-> hardPending == '0);
endmodule

// File: rtl/irq_master_regs.sv
module irq_master_regs
  import irqm_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] devIrq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] pendingOut,
  output logic [DATA_W-1:0] disabledOut,
  output logic [TGT_W-1:0]  targetCpu,
  output logic [DATA_W-1:0] hardPending
);
  strobes_t stb;
  rdSel_e   rdSel;

  initial begin
    if ((NUM_CPU & (NUM_CPU - 1)) != 0 || NUM_CPU < 1)
      $error("NUM_CPU must be a power of two");
  end

  irqm_ctrl uCtrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  irqm_datapath #(.NUM_CPU(NUM_CPU)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .devIrq      (devIrq),
    .busWdata    (busWdata),
    .stb         (stb),
    .rdSel       (rdSel),
    .busRdata    (busRdata),
    .pendingQ    (pendingOut),
    .disabledQ   (disabledOut),
    .targetQ     (targetCpu),
    .hardPending (hardPending)
  );

  p_mask_keeps_pend_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrMask || stb.setMask) |=> pendingOut == $past(devIrq));
endmodule

// File: tb/irq_master_regs_test.sv
module irq_master_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] irq;
    logic [31:0] expRd;
    logic [1:0]  expTgt;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 3'd1, 32'h0,        32'h0,        32'h0,        2'd0}, // R1
    '{1'b0, 3'd0, 32'h0,        32'h00000005, 32'h00000005, 2'd0}, // R2
    '{1'b0, 3'd0, 32'h0,        32'hFFFFFFFF, 32'h7FFFFFFF, 2'd0}, // R3
    '{1'b1, 3'd3, 32'h80000100, 32'hFFFFFFFF, 32'h0,        2'd0}, // R6
    '{1'b0, 3'd0, 32'h0,        32'hFFFFFFFF, 32'h7FFFFFFF, 2'd0}, // R7
    '{1'b0, 3'd1, 32'h0,        32'h0,        32'h80000100, 2'd0}, // R6
    '{1'b1, 3'd2, 32'hFFFFFFFF, 32'h0,        32'h0,        2'd0}, // R5
    '{1'b0, 3'd1, 32'h0,        32'h0,        32'h0,        2'd0}, // R5
    '{1'b1, 3'd3, 32'hFFFFFFFF, 32'h0,        32'h0,        2'd0}, // R6
    '{1'b0, 3'd1, 32'h0,        32'h0,        32'hF05DFF80, 2'd0}, // R4
    '{1'b1, 3'd2, 32'h0000FF00, 32'h0,        32'h0,        2'd0}, // R5
    '{1'b0, 3'd1, 32'h0,        32'h0,        32'hF05D0080, 2'd0}, // R4
    '{1'b1, 3'd4, 32'h00000007, 32'h0,        32'h0,        2'd3}, // R8
    '{1'b1, 3'd4, 32'hFFFFFFF6, 32'h0,        32'h0,        2'd2}, // R8
    '{1'b1, 3'd0, 32'hFFFFFFFF, 32'h0,        32'h0,        2'd2}, // R9
    '{1'b1, 3'd1, 32'h0,        32'h0,        32'hF05D0080, 2'd2}, // R9
    '{1'b1, 3'd5, 32'h00000001, 32'h0,        32'h0,        2'd2}, // R9
    '{1'b0, 3'd1, 32'h0,        32'h0,        32'hF05D0080, 2'd2}  // R9
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] devIrq = '0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata, pendingOut, disabledOut, hardPending;
  logic [1:0]  targetCpu;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_master_regs uut (
    .clk(clk), .rstN(rstN), .devIrq(devIrq), .busAddr(busAddr),
    .busWr(busWr), .busWdata(busWdata), .busRdata(busRdata),
    .pendingOut(pendingOut), .disabledOut(disabledOut),
    .targetCpu(targetCpu), .hardPending(hardPending)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, let one rising edge pass, sample 1 time unit later
  task automatic cycle(input logic wr, input logic [2:0] a, input logic [31:0] d,
                       input logic [31:0] irq);
    @(negedge clk);
    busWr = wr; busAddr = a; busWdata = d; devIrq = irq;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; busWr = 1'b0; devIrq = '0;
    @(posedge clk); @(posedge clk);
    #1;
    check("R1 disabled", disabledOut, 32'h0FA2007F);
    check("R1 pending", pendingOut, 32'h0);
    check("R1 target", {30'b0, targetCpu}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    for (int i = 0; i < NVEC; i++) begin
      cycle(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].irq);
      check($sformatf("vector %0d rdata", i), busRdata, VECS[i].expRd);
      check($sformatf("vector %0d R8 target", i), {30'b0, targetCpu}, {30'b0, VECS[i].expTgt});
    end
    // R10: enable all implemented sources, then observe the hard pending path
    cycle(1'b1, 3'd2, 32'hFFFFFFFF, 32'h0);
    cycle(1'b0, 3'd7, 32'h0, 32'h00000100);
    check("R10 enabled source", hardPending, 32'h00000100);
    check("R9 unused read", busRdata, 32'h0);
    cycle(1'b0, 3'd0, 32'h0, 32'h00000101);
    check("R10 reserved source blocked", hardPending, 32'h00000100);
    cycle(1'b1, 3'd3, 32'h80000000, 32'h00000100);
    check("R10 global kill", hardPending, 32'h0);
    check("R7 pending after kill", pendingOut, 32'h00000100);
    cycle(1'b1, 3'd2, 32'h80000000, 32'h00000100);
    check("R10 kill released", hardPending, 32'h00000100);
    // R1: reset in the middle of a run
    cycle(1'b1, 3'd4, 32'h1, 32'h00000100);
    doReset();
    cycle(1'b0, 3'd1, 32'h0, 32'h0);
    check("R1 mask read after reset", busRdata, 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule